// File: doc/BRIEF.md
# Keyboard Controller Host Register Port

This block models the host-visible register pair of a legacy keyboard controller. A host bus performs single-byte reads and writes at two byte addresses: one carries a status byte (read) and command codes (write), the other carries the data byte in both directions. On the device side the block accepts scancode bytes through a valid-qualified byte input and drives a three-bit LED vector.

Software polls the status byte until the output-full flag is set, then reads the data port to take the waiting byte; the read frees the buffer. Command codes start a timed self test, enable the keyboard input, or arm a set-LED sequence in which the following data-port write is taken as the LED pattern. A level interrupt that follows the output-full flag can be included by parameter.

Top module: `kbc_port_ctrl`

## Requirements
- R1: The status byte, read at address 0x64, holds (bit 0) output buffer full, (bit 1) host write busy, (bit 2) self test passed, (bit 3) last host write went to address 0x64, (bit 6) scancode lost; bits 7, 5 and 4 always read 0. After reset the status byte is 0x00.
- R2: Reading address 0x60 returns the output buffer byte, reading any address other than 0x60 or 0x64 returns 0x00, and host writes to any other address have no effect on any state.
- R3: An accepted scancode is stored in the output buffer and sets status bit 0; a host read at 0x60 clears bit 0. A scancode arriving in the same cycle as that read is accepted and bit 0 stays 1.
- R4: After reset the keyboard input is disabled and incoming scancodes change nothing; command 0xAE written to 0x64 enables it.
- R5: A scancode arriving while bit 0 is set and no data read happens in that cycle is dropped, the buffer keeps its old byte, and status bit 6 is set; a host read at 0x64 clears bit 6 unless a drop happens in that same cycle.
- R6: Command 0xAA starts a self test; ST_CYCLES clock edges after the edge that took the command, the buffer holds 0x55 and bits 0 and 2 are set, replacing any byte waiting. A scancode arriving in that completion cycle is dropped and sets bit 6. A new 0xAA restarts the count.
- R7: Status bit 1 is 1 for exactly the cycle after any host write to 0x60 or 0x64 and 0 otherwise.
- R8: Command 0xED arms the LED sequence; the next write to 0x60 loads its bits 2:0 into the LED output and disarms. A 0x60 write while not armed, and any unknown command code, leave the LEDs unchanged. Reset turns all LEDs off.
- R9: With IRQ_EN set, the interrupt output equals status bit 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational from address) |
| scan_valid | input | 1 | Scancode byte valid |
| scan_byte | input | 8 | Scancode byte |
| led_out | output | 3 | LED drive vector |
| irq | output | 1 | Level interrupt, output buffer full |

## Verification
Two pairs of functions can land in one cycle: a host data read with a new scancode, and self-test completion with a new scancode. The bench provokes the first by holding the data-port read strobe and the scancode valid together on one edge, and judges it by bit 0 staying set with the new byte visible and bit 6 clear. It provokes the second by counting exactly ST_CYCLES edges after the 0xAA write and offering a scancode on the last one, then expects 0x55 in the buffer with bit 6 set.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam logic [7:0] PORT_DATA = 8'h60;
    localparam logic [7:0] PORT_CTRL = 8'h64;
    localparam logic [7:0] OP_TEST   = 8'hAA;
    localparam logic [7:0] OP_ENABLE = 8'hAE;
    localparam logic [7:0] OP_LEDS   = 8'hED;
    localparam logic [7:0] TEST_PASS = 8'h55;

    typedef struct packed {
        logic parity_err;
        logic scan_lost;
        logic aux_full;
        logic lock;
        logic last_cmd;
        logic sys_ok;
        logic in_busy;
        logic out_full;
    } kbc_status_t;

    typedef struct packed {
        logic       wr_any;
        logic       wr_ctrl;
        logic       rd_data;
        logic       rd_ctrl;
        logic       start_test;
        logic       enable_kbd;
        logic       arm_leds;
        logic       led_write;
        logic [7:0] wbyte;
    } host_act_t;

    function automatic logic is_port(input logic [7:0] a);
        return (a == PORT_DATA) || (a == PORT_CTRL);
    endfunction

endpackage

// File: rtl/kbc_host_decode.sv
module kbc_host_decode
    import kbc_pkg::*;
(
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       led_armed,
    output host_act_t  act
);
    logic sel_ctrl, sel_data;

    always_comb begin
        sel_ctrl       = (host_addr == PORT_CTRL);
        sel_data       = (host_addr == PORT_DATA);
        act            = '0;
        act.wbyte      = host_wdata;
        act.wr_any     = host_wr && is_port(host_addr);
        act.wr_ctrl    = host_wr && sel_ctrl;
        act.rd_data    = host_rd && sel_data;
        act.rd_ctrl    = host_rd && sel_ctrl;
        act.start_test = act.wr_ctrl && (host_wdata == OP_TEST);
        act.enable_kbd = act.wr_ctrl && (host_wdata == OP_ENABLE);
        act.arm_leds   = act.wr_ctrl && (host_wdata == OP_LEDS);
        act.led_write  = host_wr && sel_data && led_armed;
    end
endmodule

// File: rtl/kbc_selftest.sv
module kbc_selftest #(
    parameter int ST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done,
    output logic running
);
    localparam int CNT_W = $clog2(ST_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CNT_W'(ST_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign running = (cnt != '0);
    assign done    = (cnt == CNT_W'(1)) && !start;

    // R6: a start always leaves the test running on the next cycle
    p_start_runs_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> running);
endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf
    import kbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       kbd_en,
    input  logic       scan_valid,
    input  logic [7:0] scan_byte,
    input  logic       rd_data,
    input  logic       rd_ctrl,
    input  logic       test_done,
    output logic [7:0] obuf,
    output logic       obf,
    output logic       lost
);
    logic offered, free, accept, drop;

    always_comb begin
        offered = scan_valid && kbd_en;
        free    = !obf || rd_data;
        accept  = offered && free && !test_done;
        drop    = offered && (test_done || !free);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            obuf <= '0;
            obf  <= 1'b0;
        end else if (test_done) begin
            obuf <= TEST_PASS;
            obf  <= 1'b1;
        end else if (accept) begin
            obuf <= scan_byte;
            obf  <= 1'b1;
        end else if (rd_data) begin
            obf  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            lost <= 1'b0;
        else if (drop)
            lost <= 1'b1;
        else if (rd_ctrl)
            lost <= 1'b0;
    end

    // R5: a full buffer with no read loses the new byte and flags it
    p_overrun_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (scan_valid && kbd_en && obf && !rd_data) |=> (lost && $stable(obuf)));
    // R3: a data read with nothing arriving empties the buffer
    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !scan_valid && !test_done) |=> !obf);
    // R4: with the input disabled, scancodes leave the buffer alone
    p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        (!kbd_en && !test_done && !rd_data) |=> ($stable(obuf) && $stable(obf)));
    // R6: completion always presents the pass byte
    p_test_result_r6: assert property (@(posedge clk) disable iff (rst)
        test_done |=> (obf && obuf == TEST_PASS));
endmodule

// File: rtl/kbc_port_ctrl.sv
module kbc_port_ctrl
    import kbc_pkg::*;
#(
    parameter int ST_CYCLES = 16,
    parameter bit IRQ_EN    = 1'b1,
    parameter int LED_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             scan_valid,
    input  logic [7:0]       scan_byte,
    output logic [LED_W-1:0] led_out,
    output logic             irq
);
    host_act_t   act;
    kbc_status_t stat;
    logic        kbd_en, led_armed, last_cmd, in_busy, sys_ok;
    logic        test_done, test_running;
    logic [7:0]  obuf;
    logic        obf, lost;

    kbc_host_decode u_dec (
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .led_armed (led_armed),
        .act       (act)
    );

    kbc_selftest #(.ST_CYCLES(ST_CYCLES)) u_test (
        .clk    (clk),
        .rst    (rst),
        .start  (act.start_test),
        .done   (test_done),
        .running(test_running)
    );

    kbc_outbuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .kbd_en    (kbd_en),
        .scan_valid(scan_valid),
        .scan_byte (scan_byte),
        .rd_data   (act.rd_data),
        .rd_ctrl   (act.rd_ctrl),
        .test_done (test_done),
        .obuf      (obuf),
        .obf       (obf),
        .lost      (lost)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kbd_en    <= 1'b0;
            led_armed <= 1'b0;
            led_out   <= '0;
            last_cmd  <= 1'b0;
            in_busy   <= 1'b0;
            sys_ok    <= 1'b0;
        end else begin
            in_busy <= act.wr_any;
            if (act.wr_any)     last_cmd  <= act.wr_ctrl;
            if (act.enable_kbd) kbd_en    <= 1'b1;
            if (test_done)      sys_ok    <= 1'b1;
            if (act.arm_leds)
                led_armed <= 1'b1;
            else if (act.led_write)
                led_armed <= 1'b0;
            if (act.led_write)
                led_out <= act.wbyte[LED_W-1:0];
        end
    end

    always_comb begin
        stat            = '0;
        stat.scan_lost  = lost;
        stat.last_cmd   = last_cmd;
        stat.sys_ok     = sys_ok;
        stat.in_busy    = in_busy;
        stat.out_full   = obf;
        if (host_addr == PORT_CTRL)
            host_rdata = stat;
        else if (host_addr == PORT_DATA)
            host_rdata = obuf;
        else
            host_rdata = 8'h00;
    end

    generate
        if (IRQ_EN) begin : g_irq
            assign irq = obf;
        end else begin : g_noirq
            assign irq = 1'b0;
        end
    endgenerate

    // R7: any port write shows busy on the following cycle only
    p_busy_set_r7: assert property (@(posedge clk) disable iff (rst)
        (host_wr && is_port(host_addr)) |=> stat.in_busy);
    p_busy_clr_r7: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && is_port(host_addr)) |=> !stat.in_busy);
    // R8: LEDs move only on an armed data write
    p_led_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && host_addr == PORT_DATA && led_armed) |=> $stable(led_out));
    // R2: writes outside the two ports touch no state
    p_foreign_wr_r2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !is_port(host_addr) && !host_rd && !scan_valid && !test_running)
        |=> ($stable(led_out) && $stable(obuf) && $stable(kbd_en)));
endmodule

// File: tb/sim_kbc_port_ctrl.sv
`timescale 1ns/100ps
module sim_kbc_port_ctrl;
    localparam int ST = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr = 1'b0, rd = 1'b0, sv = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00, sbyte = 8'h00;
    logic [7:0] rdata;
    logic [2:0] led;
    logic       irq;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    kbc_port_ctrl #(.ST_CYCLES(ST)) u0 (
        .clk(clk), .rst(rst), .host_wr(wr), .host_rd(rd), .host_addr(addr),
        .host_wdata(wdata), .host_rdata(rdata), .scan_valid(sv),
        .scan_byte(sbyte), .led_out(led), .irq(irq)
    );

    // behavioural reference
    bit [7:0] m_buf; bit m_full, m_lost, m_busy, m_last, m_sys, m_en, m_arm;
    bit [2:0] m_led; int m_cnt;

    always @(posedge clk) begin
        bit wc, wd, rdd, rdc, done, fr;
        if (rst) begin
            m_buf <= 0; m_full <= 0; m_lost <= 0; m_busy <= 0; m_last <= 0;
            m_sys <= 0; m_en <= 0; m_arm <= 0; m_led <= 0; m_cnt <= 0;
        end else begin
            wc = wr && addr == 8'h64; wd = wr && addr == 8'h60;
            rdd = rd && addr == 8'h60; rdc = rd && addr == 8'h64;
            done = (m_cnt == 1) && !(wc && wdata == 8'hAA);
            fr = !m_full || rdd;
            if (wc && wdata == 8'hAA) m_cnt <= ST;
            else if (m_cnt > 0) m_cnt <= m_cnt - 1;
            if (done) begin m_buf <= 8'h55; m_full <= 1; m_sys <= 1; end
            else if (sv && m_en && fr) begin m_buf <= sbyte; m_full <= 1; end
            else if (rdd) m_full <= 0;
            if (sv && m_en && (done || !fr)) m_lost <= 1;
            else if (rdc) m_lost <= 0;
            m_busy <= wc || wd;
            if (wc || wd) m_last <= wc;
            if (wc && wdata == 8'hAE) m_en <= 1;
            if (wc && wdata == 8'hED) m_arm <= 1;
            else if (wd && m_arm) m_arm <= 0;
            if (wd && m_arm) m_led <= wdata[2:0];
        end
    end

    function automatic bit [7:0] m_rdata(input bit [7:0] a);
        if (a == 8'h64) return {1'b0, m_lost, 2'b00, m_last, m_sys, m_busy, m_full};
        if (a == 8'h60) return m_buf;
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) begin
            check("R2 model read byte", rdata, m_rdata(addr));
            check("R8 model leds", {5'b0, led}, {5'b0, m_led});
            check("R9 model irq", {7'b0, irq}, {7'b0, m_full});
        end
    endtask

    task automatic idle(); wr = 0; rd = 0; sv = 0; endtask

    task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1; tick(); wr = 0;
    endtask

    task automatic hread(input logic [7:0] a);
        addr = a; rd = 1; tick(); rd = 0;
    endtask

    task automatic scan(input logic [7:0] b);
        sbyte = b; sv = 1; tick(); sv = 0;
    endtask

    function automatic logic [7:0] peek_dummy(input int x); return 8'(x); endfunction

    task automatic peek(input logic [7:0] a, input string tag, input logic [7:0] exp);
        addr = a; #0.5; check(tag, rdata, exp);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0; idle();
        tick();
        peek(8'h64, "R1 reset status", 8'h00);
        check("R8 reset leds", {5'b0, led}, 8'h00);
        check("R9 reset irq", {7'b0, irq}, 8'h00);

        scan(8'h1C);
        peek(8'h64, "R4 disabled ignores scancode", 8'h00);

        hwrite(8'h64, 8'hAE);
        peek(8'h64, "R7 busy after command", 8'h0A);
        tick();
        peek(8'h64, "R7 busy drops", 8'h08);

        scan(8'h1C);
        peek(8'h64, "R3 full after scancode", 8'h09);
        check("R9 irq follows full", {7'b0, irq}, 8'h01);
        peek(8'h60, "R3 data byte", 8'h1C);

        scan(8'h32);
        peek(8'h64, "R5 lost flag", 8'h49);
        peek(8'h60, "R5 old byte kept", 8'h1C);
        hread(8'h64);
        peek(8'h64, "R5 status read clears lost", 8'h09);

        addr = 8'h60; rd = 1; sbyte = 8'h2A; sv = 1; tick(); idle();
        peek(8'h64, "R3 read and scancode same cycle", 8'h09);
        peek(8'h60, "R3 new byte after shared cycle", 8'h2A);
        hread(8'h60);
        peek(8'h64, "R3 read empties buffer", 8'h08);
        check("R9 irq low when empty", {7'b0, irq}, 8'h00);

        hwrite(8'h60, 8'h07);
        check("R8 unarmed data write", {5'b0, led}, 8'h00);
        peek(8'h64, "R7 busy after data write", 8'h02);
        hwrite(8'h64, 8'hED);
        hwrite(8'h64, 8'h12);
        hwrite(8'h60, 8'hFD);
        check("R8 armed write sets leds", {5'b0, led}, 8'h05);
        hwrite(8'h60, 8'h02);
        check("R8 second write ignored", {5'b0, led}, 8'h05);

        hwrite(8'h20, 8'hED);
        peek(8'h20, "R2 foreign read", 8'h00);
        hwrite(8'h60, 8'h01);
        check("R2 foreign write no arm", {5'b0, led}, 8'h05);

        scan(8'h11);
        hwrite(8'h64, 8'hAA);
        for (int i = 0; i < ST - 1; i++) tick();
        peek(8'h60, "R6 not done early", 8'h11);
        tick();
        peek(8'h60, "R6 pass byte", 8'h55);
        peek(8'h64, "R6 status after test", 8'h0D);

        hread(8'h60);
        hwrite(8'h64, 8'hAA);
        for (int i = 0; i < ST - 1; i++) tick();
        sbyte = 8'h3B; sv = 1; tick(); sv = 0;
        peek(8'h60, "R6 completion beats scancode", 8'h55);
        peek(8'h64, "R6 collision sets lost", 8'h4D);

        repeat (4) tick();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule